// File: doc/BRIEF.md
# Priority-Threshold Interrupt Claim Controller

This core collects interrupt requests from a set of source gateways and routes them to several hart contexts. Every source has a programmable priority, every (source, context) pair has an enable bit, and every context has its own threshold. For each context the core picks, among the sources that are pending and enabled for that context, the one with the largest priority. It raises that context's interrupt line when the winner's priority is strictly greater than the context's threshold.

Software reaches the core through a single-cycle register port. Reading a context's claim register takes the current winner for that context: the read returns its source number, clears its pending bit and marks it in service, so no other context can take it. While in service, further gateway requests for that source are dropped. A later completion write of the same number from a context that has the source enabled ends the service period, and the gateway can then pend it again.

The winner for each context is computed combinationally from the stored state and registered once per clock. The interrupt lines and the claim reads therefore reflect the state of the previous cycle.

Top module: `ictl_core`

## Requirements
- R1: After reset all interrupt lines are low, and every priority, enable, threshold and pending read returns 0.
- R2: A high bit `gw_req_i[s-1]` for one clock sets the pending flag of source s (s from 1 to NSRC) unless that source is in service; the pending vector reads back at register 0x80 with source s at bit s and bit 0 always 0.
- R3: `irq_o[c]` is high one clock after the state shows a pending, enabled source whose priority exceeds the threshold of context c; a winner whose priority equals or lies below the threshold keeps the line low.
- R4: A source with priority 0 never raises an interrupt line and is never returned by a claim.
- R5: Among qualifying sources the larger priority wins; on equal priority the smaller source number wins.
- R6: A read of the claim register 0x60+c returns the registered winner of context c, clears its pending flag and puts it in service; if that winner is absent or no longer pending and enabled, the read returns 0 and changes nothing.
- R7: A source in service cannot be claimed by any context, and gateway requests for it are dropped.
- R8: A write of source number n to 0x60+c ends the service of n only when n is in service and enabled for context c; any other completion write is ignored.
- R9: Address bits [7:5] select the register group (0 priority of source [4:0], 1 enable word of context [4:0], 2 threshold of context [4:0], 3 claim/complete of context [4:0], 4 pending vector); a read returns its data with `rvalid_o` high on the next clock, and a write raises no response.
- R10: Enable words are kept separately for each context (bit s enables source s); a source enabled for one context has no effect on a context that does not enable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_req_i | input | NSRC | Request pulses from source gateways, bit s-1 for source s |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rvalid_o | output | 1 | Read data valid, one clock after a read |
| rdata_o | output | DW | Read data |
| irq_o | output | NCTX | Interrupt line for each context |

## Verification
The bench aims at equal-priority ties, where a design that compared with greater-or-equal would hand out the higher-numbered source, and at a winner equal to the threshold, where an off-by-one comparison would raise a spurious interrupt. It claims one source from two contexts and pulses the gateway of a source in service, which a design that failed to clear pending or to block the gateway would answer with a duplicate claim or a pending bit of 1. Completion writes from a context without the source enabled must leave the source blocked, and back-to-back random claims right after another claim check that a stale registered winner is never handed out twice.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    // Register group selected by the top address bits
    typedef enum logic [2:0] {
        GRP_PRIO  = 3'd0,
        GRP_EN    = 3'd1,
        GRP_THR   = 3'd2,
        GRP_CLAIM = 3'd3,
        GRP_PEND  = 3'd4
    } grp_e;

endpackage

// File: rtl/ictl_gate_store.sv
// Pending and in-service flags for every source; bit 0 is the null source.
module ictl_gate_store #(
    parameter int NSRC = 31,
    parameter int IW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC:0] req_i,
    input  logic          take_i,
    input  logic [IW-1:0] take_id_i,
    input  logic          done_i,
    input  logic [IW-1:0] done_id_i,
    output logic [NSRC:0] pend_o,
    output logic [NSRC:0] busy_o
);

    logic [NSRC:0] take_vec, done_vec, pend_d, busy_d;

    always_comb begin
        for (int s = 0; s <= NSRC; s++) begin
            take_vec[s] = take_i && (int'(take_id_i) == s);
            done_vec[s] = done_i && (int'(done_id_i) == s);
        end
        pend_d = (pend_o | (req_i & ~busy_o)) & ~take_vec;
        busy_d = (busy_o | take_vec) & ~done_vec;
        pend_d[0] = 1'b0;
        busy_d[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= '0;
            busy_o <= '0;
        end else begin
            pend_o <= pend_d;
            busy_o <= busy_d;
        end
    end

endmodule

// File: rtl/ictl_ctx_arb.sv
// Winner selection for one context, registered once per clock.
module ictl_ctx_arb #(
    parameter int NSRC = 31,
    parameter int PW   = 3,
    parameter int IW   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC:0]          cand_i,
    input  logic [NSRC:0][PW-1:0]  prio_i,
    input  logic [PW-1:0]          thr_i,
    output logic [IW-1:0]          win_id_o,
    output logic                   irq_o
);

    logic [IW-1:0] best_id;
    logic [PW-1:0] best_p;

    // Strict compare keeps the lower source on a tie; best_p starts at 0
    // so a priority-0 source can never win.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (cand_i[s] && (prio_i[s] > best_p)) begin
                best_id = IW'(s);
                best_p  = prio_i[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_id_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            win_id_o <= best_id;
            irq_o    <= (best_p > thr_i);
        end
    end

endmodule

// File: rtl/ictl_core.sv
module ictl_core #(
    parameter int NSRC = 31,
    parameter int NCTX = 4,
    parameter int PW   = 3,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] gw_req_i,
    input  logic            req_i,
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic            rvalid_o,
    output logic [DW-1:0]   rdata_o,
    output logic [NCTX-1:0] irq_o
);
    import ictl_pkg::*;

    localparam int IW  = $clog2(NSRC + 1);
    localparam int IXW = AW - 3;

    grp_e           grp;
    logic [IXW-1:0] idx;
    logic           idx_src, idx_ctx;

    logic [NSRC:0][PW-1:0] prio_q;
    logic [NSRC:0]         en_q  [NCTX];
    logic [PW-1:0]         thr_q [NCTX];
    logic [IW-1:0]         win_id [NCTX];
    logic [NSRC:0]         pend_q, busy_q, gw_vec;

    logic          claim_go, claim_take, done_go, done_ok;
    logic [IW-1:0] claim_id, done_id;
    logic [NSRC:0] sel_en;
    logic [DW-1:0] rd_d;

    assign grp     = grp_e'(addr_i[AW-1 -: 3]);
    assign idx     = addr_i[IXW-1:0];
    assign idx_src = (int'(idx) >= 1) && (int'(idx) <= NSRC);
    assign idx_ctx = int'(idx) < NCTX;
    assign gw_vec  = {gw_req_i, 1'b0};

    always_comb begin
        sel_en = '0;
        for (int c = 0; c < NCTX; c++)
            if (int'(idx) == c) sel_en = en_q[c];
    end

    // Claim: registered winner of the addressed context, if still valid
    always_comb begin
        claim_id = '0;
        for (int c = 0; c < NCTX; c++)
            if (int'(idx) == c) claim_id = win_id[c];
    end
    assign claim_go   = req_i && !we_i && (grp == GRP_CLAIM) && idx_ctx;
    assign claim_take = claim_go && (claim_id != '0) && pend_q[claim_id] && sel_en[claim_id];

    // Completion: source must be in service and enabled for this context
    assign done_id = wdata_i[IW-1:0];
    assign done_go = req_i && we_i && (grp == GRP_CLAIM) && idx_ctx;
    assign done_ok = done_go && (wdata_i[DW-1:IW] == '0) && (done_id != '0) &&
                     (int'(done_id) <= NSRC) && busy_q[done_id] && sel_en[done_id];

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (req_i && we_i) begin
            unique case (grp)
                GRP_PRIO: if (idx_src) prio_q[idx] <= wdata_i[PW-1:0];
                GRP_EN: begin
                    for (int c = 0; c < NCTX; c++)
                        if (int'(idx) == c) en_q[c] <= {wdata_i[NSRC:1], 1'b0};
                end
                GRP_THR: begin
                    for (int c = 0; c < NCTX; c++)
                        if (int'(idx) == c) thr_q[c] <= wdata_i[PW-1:0];
                end
                default: ;
            endcase
        end
    end

    ictl_gate_store #(.NSRC(NSRC), .IW(IW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (gw_vec),
        .take_i    (claim_take),
        .take_id_i (claim_id),
        .done_i    (done_ok),
        .done_id_i (done_id),
        .pend_o    (pend_q),
        .busy_o    (busy_q)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ictl_ctx_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) arb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand_i   (pend_q & en_q[c]),
            .prio_i   (prio_q),
            .thr_i    (thr_q[c]),
            .win_id_o (win_id[c]),
            .irq_o    (irq_o[c])
        );
    end

    // Read data
    always_comb begin
        rd_d = '0;
        unique case (grp)
            GRP_PRIO:  if (idx_src) rd_d = DW'(prio_q[idx]);
            GRP_EN:    if (idx_ctx) rd_d = DW'(sel_en);
            GRP_THR: begin
                for (int c = 0; c < NCTX; c++)
                    if (int'(idx) == c) rd_d = DW'(thr_q[c]);
            end
            GRP_CLAIM: if (claim_take) rd_d = DW'(claim_id);
            GRP_PEND:  rd_d = DW'(pend_q);
            default:   rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= req_i && !we_i;
            rdata_o  <= (req_i && !we_i) ? rd_d : '0;
        end
    end

endmodule

// File: rtl/ictl_core_chk.sv
module ictl_core_chk #(
    parameter int NSRC = 31,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic            we_i,
    input logic [AW-1:0]   addr_i,
    input logic [NSRC-1:0] gw_req_i,
    input logic            rvalid_o,
    input logic [DW-1:0]   rdata_o,
    input logic [NSRC:0]   pend_q,
    input logic [NSRC:0]   busy_q
);
    localparam int IW = $clog2(NSRC + 1);

    logic claim_rd, grp_claim;
    assign grp_claim = (addr_i[AW-1 -: 3] == 3'd3);
    assign claim_rd  = req_i && !we_i && grp_claim;

    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i) |=> rvalid_o);

    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i || we_i) |=> !rvalid_o);

    // A source is never pending and in service at once
    p_pend_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & busy_q) == '0);

    p_claim_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_rd |=> (int'(rdata_o) <= NSRC) &&
                     ((rdata_o == '0) || busy_q[rdata_o[IW-1:0]]));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && grp_claim) |=> $stable(busy_q));

    p_pend_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ((pend_q & ~$past(pend_q) & ~$past({gw_req_i, 1'b0})) == '0));

endmodule

bind ictl_core ictl_core_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .gw_req_i (gw_req_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o),
    .pend_q   (pend_q),
    .busy_q   (busy_q)
);

// File: tb/ictl_core_tb_top.sv
`timescale 1ns/1ps
module ictl_core_tb_top;
    localparam int NSRC = 31;
    localparam int NCTX = 4;
    localparam int PW   = 3;
    localparam int AW   = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] gw_req_i = '0;
    logic            req_i = 1'b0;
    logic            we_i = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic [DW-1:0]   wdata_i = '0;
    logic            rvalid_o;
    logic [DW-1:0]   rdata_o;
    logic [NCTX-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ictl_core #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .gw_req_i(gw_req_i), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
        .irq_o(irq_o)
    );

    // ---------------- behavioural reference ----------------
    int          m_prio [32];
    bit [31:0]   m_en   [4];
    int          m_thr  [4];
    bit          m_pend [32];
    bit          m_busy [32];
    int          m_win  [4];
    bit          m_irq  [4];
    bit          m_rv;
    bit [31:0]   m_rd;

    initial begin
        for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_busy[i] = 0; end
        for (int c = 0; c < 4; c++) begin m_en[c] = 0; m_thr[c] = 0; m_win[c] = 0; m_irq[c] = 0; end
        m_rv = 0; m_rd = 0;
    end

    always @(posedge clk) begin
        int  nw [4];
        bit  ni [4];
        bit  ob [32];
        int  grp, ix, id, bp;
        bit  rv;
        bit [31:0] rd;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_busy[i] = 0; end
            for (int c = 0; c < 4; c++) begin m_en[c] = 0; m_thr[c] = 0; m_win[c] = 0; m_irq[c] = 0; end
            m_rv = 0; m_rd = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                nw[c] = 0; bp = 0;
                for (int s = 1; s <= NSRC; s++)
                    if (m_pend[s] && m_en[c][s] && m_prio[s] > bp) begin nw[c] = s; bp = m_prio[s]; end
                ni[c] = bp > m_thr[c];
            end
            for (int s = 0; s < 32; s++) ob[s] = m_busy[s];
            grp = int'(addr_i[7:5]); ix = int'(addr_i[4:0]);
            rv = 0; rd = 0;
            if (req_i && !we_i) begin
                rv = 1;
                case (grp)
                    0: if (ix >= 1) rd = m_prio[ix];
                    1: if (ix < 4) rd = m_en[ix];
                    2: if (ix < 4) rd = m_thr[ix];
                    3: if (ix < 4) begin
                        id = m_win[ix];
                        if (id != 0 && m_pend[id] && m_en[ix][id]) begin
                            rd = id; m_pend[id] = 0; m_busy[id] = 1;
                        end
                    end
                    4: for (int s = 1; s <= NSRC; s++) rd[s] = m_pend[s];
                    default: ;
                endcase
            end
            if (req_i && we_i) begin
                case (grp)
                    0: if (ix >= 1) m_prio[ix] = int'(wdata_i[2:0]);
                    1: if (ix < 4) m_en[ix] = wdata_i & 32'hFFFF_FFFE;
                    2: if (ix < 4) m_thr[ix] = int'(wdata_i[2:0]);
                    3: if (ix < 4 && wdata_i < 32 && wdata_i != 0) begin
                        id = int'(wdata_i);
                        if (m_busy[id] && m_en[ix][id]) m_busy[id] = 0;
                    end
                    default: ;
                endcase
            end
            for (int s = 1; s <= NSRC; s++)
                if (gw_req_i[s-1] && !ob[s] && !m_busy[s]) m_pend[s] = 1;
            for (int c = 0; c < 4; c++) begin m_win[c] = nw[c]; m_irq[c] = ni[c]; end
            m_rv = rv; m_rd = rd;
        end
    end

    // Compare against the reference on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int c = 0; c < NCTX; c++) begin
                checks++;
                if (irq_o[c] !== m_irq[c]) begin
                    errors++;
                    $display("FAIL R3 irq_o[%0d] actual=%0b expected=%0b t=%0t", c, irq_o[c], m_irq[c], $time);
                end
            end
            checks++;
            if (rvalid_o !== m_rv) begin
                errors++;
                $display("FAIL R9 rvalid_o actual=%0b expected=%0b t=%0t", rvalid_o, m_rv, $time);
            end
            if (m_rv) begin
                checks++;
                if (rdata_o !== m_rd) begin
                    errors++;
                    $display("FAIL R6 rdata_o actual=%0h expected=%0h t=%0t", rdata_o, m_rd, $time);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 0; we_i = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_i = 1; we_i = 0; addr_i = a;
        @(negedge clk);
        req_i = 0;
        checks++;
        if (!rvalid_o || rdata_o !== exp) begin
            errors++;
            $display("FAIL %s read %0h actual=%0h expected=%0h", tag, a, rdata_o, exp);
        end
        @(negedge clk);
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk);
        gw_req_i = m;
        @(negedge clk);
        gw_req_i = '0;
    endtask

    task automatic irq_chk(input int c, input bit exp, input string tag);
        checks++;
        if (irq_o[c] !== exp) begin
            errors++;
            $display("FAIL %s irq_o[%0d] actual=%0b expected=%0b", tag, c, irq_o[c], exp);
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        // R1: reset state
        for (int c = 0; c < NCTX; c++) irq_chk(c, 0, "R1");
        rd_chk(8'h05, 0, "R1");
        rd_chk(8'h21, 0, "R1");
        rd_chk(8'h42, 0, "R1");
        rd_chk(8'h80, 0, "R1");

        // configuration
        wr(8'h03, 2); wr(8'h05, 5); wr(8'h07, 5); wr(8'h09, 0);
        wr(8'h40, 1); wr(8'h41, 5);
        wr(8'h20, 32'h2A8); wr(8'h21, 32'h220); wr(8'h22, 32'h200); wr(8'h23, 0);

        pulse((31'd1 << 2) | (31'd1 << 4) | (31'd1 << 6) | (31'd1 << 8));
        rd_chk(8'h80, 32'h2A8, "R2");
        idle(2);
        irq_chk(0, 1, "R3");
        irq_chk(1, 0, "R3 at threshold");
        irq_chk(2, 0, "R4 prio zero");
        irq_chk(3, 0, "R10");

        rd_chk(8'h60, 5, "R5 tie lower id");
        rd_chk(8'h60, 7, "R6");
        rd_chk(8'h60, 3, "R6");
        rd_chk(8'h60, 0, "R4 nothing left");
        rd_chk(8'h61, 0, "R7 taken by other ctx");

        pulse(31'd1 << 4);
        rd_chk(8'h80, 32'h200, "R7 gateway blocked");
        wr(8'h62, 5);
        pulse(31'd1 << 4);
        rd_chk(8'h80, 32'h200, "R8 foreign complete ignored");
        wr(8'h60, 5);
        pulse(31'd1 << 4);
        rd_chk(8'h80, 32'h220, "R8 complete frees source");

        wr(8'h41, 4);
        idle(2);
        irq_chk(1, 1, "R3 above threshold");
        irq_chk(3, 0, "R10");
        wr(8'h05, 0);
        idle(2);
        irq_chk(1, 0, "R4 prio zero");
        rd_chk(8'h21, 32'h220, "R10");
        rd_chk(8'h41, 4, "R9");
        rd_chk(8'h65, 0, "R9 out of range ctx");

        // random traffic, reference compared every clock
        for (int n = 0; n < 4000; n++) begin
            int g;
            @(negedge clk);
            g = $urandom_range(0, 5);
            req_i  = ($urandom_range(0, 3) != 0);
            we_i   = $urandom_range(0, 1);
            addr_i = {3'(g), (g == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 4))};
            case (g)
                1: wdata_i = $urandom;
                3: wdata_i = ($urandom_range(0, 9) == 0) ? 32'h40 : 32'($urandom_range(0, 31));
                default: wdata_i = 32'($urandom_range(0, 7));
            endcase
            gw_req_i = 31'($urandom & $urandom & $urandom);
        end
        @(negedge clk);
        req_i = 0; we_i = 0; gw_req_i = '0;
        idle(3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule